// File: doc/BRIEF.md
# DMA Channel Status and Acknowledge Logic

This block keeps the status flags of one DMA channel and produces the qualifier that gates the channel's acknowledge strobe. The transfer engine sends it single-cycle event pulses: a start, the end of the last transfer, bus errors seen in the read or write phase, and the appearance of a pending transfer. It also receives the channel-selected level, the live byte count, both addresses and the transfer size. The block checks the channel setup when a start arrives. It records any error that ends the channel and keeps a request bit while work is waiting for the channel. Software reads all of this as one 8-bit status word.

Software acknowledges a finished or failed channel by writing a 1 into the done position of the status word. That one write clears done and all three error flags. A new start is refused while any error flag remains set. The acknowledge qualifier has two modes. In the first it is high on every selection made for an external request. In the second it is high only during the final transfer.

Top module: `dma_chan_status`

## Requirements
- R1: After a synchronous reset every flag is 0 and `status_o` reads 0x00.
- R2: A start taken while the byte count is zero sets the configuration-error flag (bit 6) and done (bit 0), and leaves busy (bit 1) clear, one cycle after the start.
- R3: With size code 0=1 byte, 1=2 bytes, 2=4 bytes, 3=16 bytes, a start also sets the configuration-error flag and done if the byte count, source address or destination address is not a multiple of the size. Otherwise the start is valid: busy sets and done clears.
- R4: A start is ignored while busy is set or while any error flag (bits 6, 5, 4) is set.
- R5: An end-of-transfer pulse while busy sets done and clears busy. An end pulse while idle has no effect.
- R6: While busy, a read-phase bus error, or a write-phase bus error with single-address mode on, sets the source-bus-error flag (bit 5), sets done and clears busy.
- R7: While busy, a write-phase bus error in dual-address mode sets the destination-bus-error flag (bit 4), sets done and clears busy.
- R8: A register write with data bit 0 at 1 clears done and the flags in bits 6, 5 and 4. Busy and request are left alone. A write with data bit 0 at 0 changes nothing. An event that sets a flag in the same cycle wins over the clear.
- R9: Bits 7 and 3 of `status_o` always read 0.
- R10: Request (bit 2) sets on a pending pulse while busy and not selected. It clears in the cycle after the channel is selected and when the channel terminates.
- R11: With `ack_final_i` at 0, `ack_o` equals selected AND external-request in the same cycle.
- R12: With `ack_final_i` at 1, `ack_o` is high only while selected for an external request and the byte count equals the transfer size in bytes. That is the final transfer, in both its read and its write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse from the engine |
| sel_i | input | 1 | Channel is currently selected |
| ext_req_i | input | 1 | Selection is due to an external request |
| pend_i | input | 1 | Pulse: a transfer is pending |
| rd_berr_i | input | 1 | Bus error in the read phase |
| wr_berr_i | input | 1 | Bus error in the write phase |
| single_addr_i | input | 1 | Single-address mode |
| end_i | input | 1 | Pulse: final transfer finished |
| ack_final_i | input | 1 | Acknowledge only on the final transfer |
| size_i | input | 2 | Transfer size code |
| cnt_i | input | CNT_W | Current byte count |
| src_i | input | ADDR_W | Source address |
| dst_i | input | ADDR_W | Destination address |
| wr_en_i | input | 1 | Status register write strobe |
| wr_data_i | input | 8 | Status register write data |
| status_o | output | 8 | Status word |
| ack_o | output | 1 | Acknowledge qualifier |

## Verification
The hardest situation to reach is a refused start. It needs an error flag that is still held from an earlier terminated run. The stimulus reaches it by running valid starts, injecting each kind of bus error in both address modes, and then issuing another start before the clearing write. The configuration check is swept over every size code and every low-order offset of each of the three operands. A pending pulse that arrives together with a selection is also driven, which covers the request-bit priority.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_LINE = 2'b11
    } xfer_size_e;

    typedef struct packed {
        logic ce;
        logic bes;
        logic bed;
        logic req;
        logic busy;
        logic done;
    } chan_flags_t;

    localparam int STAT_W  = 8;
    localparam int B_DONE  = 0;
    localparam int B_BUSY  = 1;
    localparam int B_REQ   = 2;
    localparam int B_BED   = 4;
    localparam int B_BES   = 5;
    localparam int B_CE    = 6;
    localparam int SZB_W   = 5;

    function automatic logic [SZB_W-1:0] size_bytes(xfer_size_e s);
        case (s)
            SZ_BYTE: return 5'd1;
            SZ_HALF: return 5'd2;
            SZ_WORD: return 5'd4;
            default: return 5'd16;
        endcase
    endfunction

    function automatic logic [SZB_W-2:0] low_mask(xfer_size_e s);
        logic [SZB_W-1:0] b;
        b = size_bytes(s) - 5'd1;
        return b[SZB_W-2:0];
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(chan_flags_t f);
        logic [STAT_W-1:0] w;
        w         = '0;
        w[B_CE]   = f.ce;
        w[B_BES]  = f.bes;
        w[B_BED]  = f.bed;
        w[B_REQ]  = f.req;
        w[B_BUSY] = f.busy;
        w[B_DONE] = f.done;
        return w;
    endfunction

endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
    import dma_stat_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 32
) (
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  xfer_size_e        size_i,
    output logic              cfg_bad_o
);
    localparam int MW = SZB_W - 1;

    logic [MW-1:0]     msk;
    logic [CNT_W-1:0]  cnt_msk;
    logic [ADDR_W-1:0] adr_msk;
    logic              cnt_zero, mis_cnt, mis_src, mis_dst;

    always_comb begin
        msk       = low_mask(size_i);
        cnt_msk   = CNT_W'(msk);
        adr_msk   = ADDR_W'(msk);
        cnt_zero  = (cnt_i == '0);
        mis_cnt   = |(cnt_i & cnt_msk);
        mis_src   = |(src_i & adr_msk);
        mis_dst   = |(dst_i & adr_msk);
        cfg_bad_o = cnt_zero | mis_cnt | mis_src | mis_dst;
    end
endmodule

// File: rtl/dma_ack_gen.sv
module dma_ack_gen
    import dma_stat_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_i,
    input  logic             ext_req_i,
    input  logic             final_only_i,
    input  xfer_size_e       size_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             ack_o
);
    logic last_xfer;

    always_comb begin
        last_xfer = (cnt_i == CNT_W'(size_bytes(size_i)));
        ack_o     = sel_i & ext_req_i & (~final_only_i | last_xfer);
    end

    p_ack_final_r12: assert property (@(posedge clk) disable iff (rst)
        (ack_o && final_only_i) |-> (cnt_i == CNT_W'(size_bytes(size_i))));
    p_ack_sel_r11: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> (sel_i && ext_req_i));
endmodule

// File: rtl/dma_stat_regs.sv
module dma_stat_regs
    import dma_stat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        cfg_bad_i,
    input  logic        sel_i,
    input  logic        pend_i,
    input  logic        rd_berr_i,
    input  logic        wr_berr_i,
    input  logic        single_addr_i,
    input  logic        end_i,
    input  logic        clr_i,
    output chan_flags_t flags_o
);
    chan_flags_t f_q, f_n;
    logic        err_any, term;

    always_comb begin
        f_n     = f_q;
        err_any = f_q.ce | f_q.bes | f_q.bed;
        term    = 1'b0;
        if (clr_i) begin
            f_n.done = 1'b0;
            f_n.ce   = 1'b0;
            f_n.bes  = 1'b0;
            f_n.bed  = 1'b0;
        end
        if (start_i && !f_q.busy && !err_any) begin
            if (cfg_bad_i) begin
                f_n.ce   = 1'b1;
                f_n.done = 1'b1;
            end else begin
                f_n.busy = 1'b1;
                f_n.done = 1'b0;
            end
        end
        if (f_q.busy) begin
            if (rd_berr_i || (wr_berr_i && single_addr_i)) begin
                f_n.bes = 1'b1;
                term    = 1'b1;
            end
            if (wr_berr_i && !single_addr_i) begin
                f_n.bed = 1'b1;
                term    = 1'b1;
            end
            if (end_i) term = 1'b1;
            if (term) begin
                f_n.busy = 1'b0;
                f_n.done = 1'b1;
                f_n.req  = 1'b0;
            end else if (sel_i) begin
                f_n.req = 1'b0;
            end else if (pend_i) begin
                f_n.req = 1'b1;
            end
        end else if (sel_i) begin
            f_n.req = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) f_q <= '0;
        else     f_q <= f_n;
    end

    assign flags_o = f_q;

    p_busy_done_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(f_q.busy && f_q.done));
    p_err_done_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(f_q.bes) || $rose(f_q.bed)) |-> f_q.done);
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !start_i && !end_i && !rd_berr_i && !wr_berr_i)
        |=> (!f_q.done && !f_q.ce && !f_q.bes && !f_q.bed));
    p_req_sel_r10: assert property (@(posedge clk) disable iff (rst)
        sel_i |=> !f_q.req);
    p_refuse_r4: assert property (@(posedge clk) disable iff (rst)
        (start_i && !f_q.busy && (f_q.ce || f_q.bes || f_q.bed)) |=> !f_q.busy);
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
    import dma_stat_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              sel_i,
    input  logic              ext_req_i,
    input  logic              pend_i,
    input  logic              rd_berr_i,
    input  logic              wr_berr_i,
    input  logic              single_addr_i,
    input  logic              end_i,
    input  logic              ack_final_i,
    input  logic [1:0]        size_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic              wr_en_i,
    input  logic [7:0]        wr_data_i,
    output logic [7:0]        status_o,
    output logic              ack_o
);
    xfer_size_e  size_e;
    logic        cfg_bad, clr;
    chan_flags_t flags;
    logic        unused_wr;

    assign size_e    = xfer_size_e'(size_i);
    assign clr       = wr_en_i & wr_data_i[B_DONE];
    assign unused_wr = ^wr_data_i[7:1];

    dma_cfg_check #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
        .cnt_i(cnt_i), .src_i(src_i), .dst_i(dst_i),
        .size_i(size_e), .cfg_bad_o(cfg_bad)
    );

    dma_stat_regs u_regs (
        .clk(clk), .rst(rst), .start_i(start_i), .cfg_bad_i(cfg_bad),
        .sel_i(sel_i), .pend_i(pend_i), .rd_berr_i(rd_berr_i),
        .wr_berr_i(wr_berr_i), .single_addr_i(single_addr_i),
        .end_i(end_i), .clr_i(clr), .flags_o(flags)
    );

    dma_ack_gen #(.CNT_W(CNT_W)) u_ack (
        .clk(clk), .rst(rst), .sel_i(sel_i), .ext_req_i(ext_req_i),
        .final_only_i(ack_final_i), .size_i(size_e), .cnt_i(cnt_i),
        .ack_o(ack_o)
    );

    assign status_o = pack_status(flags);

    p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (status_o[7] == 1'b0) && (status_o[3] == 1'b0));
endmodule

// File: tb/dma_chan_status_test.sv
module dma_chan_status_test;
    localparam int PERIOD = 10;
    localparam int CW = 24;
    localparam int AW = 32;

    logic clk = 0, rst = 1;
    logic start_i = 0, sel_i = 0, ext_req_i = 0, pend_i = 0;
    logic rd_berr_i = 0, wr_berr_i = 0, single_addr_i = 0, end_i = 0;
    logic ack_final_i = 0, wr_en_i = 0;
    logic [1:0] size_i = 0;
    logic [CW-1:0] cnt_i = 0;
    logic [AW-1:0] src_i = 0, dst_i = 0;
    logic [7:0] wr_data_i = 0;
    logic [7:0] status_o;
    logic ack_o;

    int total = 0, bad = 0;

    dma_chan_status #(.CNT_W(CW), .ADDR_W(AW)) uut (.*);

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
        end
    endtask

    task automatic chk_stat(string req, logic [7:0] exp);
        chk(req, {24'd0, status_o}, {24'd0, exp});
        chk("R9", {30'd0, status_o[7], status_o[3]}, 32'd0);
    endtask

    // one clock: inputs already set at a negedge, advance to the next negedge
    task automatic tick();
        @(negedge clk);
        start_i = 0; pend_i = 0; rd_berr_i = 0; wr_berr_i = 0;
        end_i = 0; wr_en_i = 0; sel_i = 0;
    endtask

    task automatic do_start();  start_i = 1; tick(); endtask
    task automatic do_end();    end_i = 1;   tick(); endtask
    task automatic do_write(logic [7:0] d);
        wr_en_i = 1; wr_data_i = d; tick();
    endtask

    function automatic int nbytes(int s);
        return (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 4 : 16;
    endfunction

    initial begin
        #(PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 0;
        chk_stat("R1", 8'h00);

        // zero count at start
        cnt_i = 0; src_i = 0; dst_i = 0; size_i = 0;
        do_start();
        chk_stat("R2", 8'h41);
        do_write(8'h01);
        chk_stat("R8", 8'h00);

        // alignment sweep over every size and low offset of each operand
        for (int s = 0; s < 4; s++) begin
            for (int fld = 0; fld < 3; fld++) begin
                for (int off = 0; off < 16; off++) begin
                    logic badcfg;
                    size_i = s[1:0];
                    cnt_i = 24'h40; src_i = 32'h100; dst_i = 32'h200;
                    if (fld == 0) cnt_i = cnt_i + CW'(off);
                    if (fld == 1) src_i = src_i + AW'(off);
                    if (fld == 2) dst_i = dst_i + AW'(off);
                    badcfg = (off % nbytes(s)) != 0;
                    do_start();
                    chk_stat("R3", badcfg ? 8'h41 : 8'h02);
                    if (!badcfg) begin
                        do_end();
                        chk_stat("R5", 8'h01);
                    end
                    do_write(8'h01);
                    chk_stat("R8", 8'h00);
                end
            end
        end

        // bus errors in both address modes
        cnt_i = 24'h40; src_i = 0; dst_i = 0; size_i = 2;
        for (int sa = 0; sa < 2; sa++) begin
            for (int wr = 0; wr < 2; wr++) begin
                logic [7:0] e;
                single_addr_i = sa[0];
                do_start();
                chk_stat("R4", 8'h02);
                if (wr == 1) wr_berr_i = 1; else rd_berr_i = 1;
                tick();
                e = (wr == 1 && sa == 0) ? 8'h11 : 8'h21;
                chk_stat((wr == 1 && sa == 0) ? "R7" : "R6", e);
                do_start();
                chk_stat("R4", e);
                do_write(8'hFE);
                chk_stat("R8", e);
                do_write(8'h01);
                chk_stat("R8", 8'h00);
            end
        end
        single_addr_i = 0;

        // end while idle ignored
        do_end();
        chk_stat("R5", 8'h00);

        // request tracking
        do_start();
        pend_i = 1; tick();
        chk_stat("R10", 8'h06);
        do_start();
        chk_stat("R4", 8'h06);
        sel_i = 1; tick();
        chk_stat("R10", 8'h02);
        pend_i = 1; sel_i = 1; tick();
        chk_stat("R10", 8'h02);
        pend_i = 1; tick();
        do_write(8'h01);
        chk_stat("R8", 8'h06);
        do_end();
        chk_stat("R10", 8'h01);
        // clear and set in one cycle: set wins
        do_write(8'h01);
        do_start();
        wr_en_i = 1; wr_data_i = 8'h01; rd_berr_i = 1; tick();
        chk_stat("R8", 8'h21);
        do_write(8'h01);
        chk_stat("R8", 8'h00);

        // acknowledge qualifier sweep
        for (int t = 0; t < 2; t++)
            for (int sl = 0; sl < 2; sl++)
                for (int ex = 0; ex < 2; ex++)
                    for (int s = 0; s < 4; s++)
                        for (int c = 0; c < 6; c++) begin
                            int cv;
                            logic e;
                            cv = (c == 0) ? 0 : (c == 1) ? 1 : (c == 2) ? 2 :
                                 (c == 3) ? 4 : (c == 4) ? 16 : 5;
                            @(negedge clk);
                            ack_final_i = t[0]; sel_i = sl[0]; ext_req_i = ex[0];
                            size_i = s[1:0]; cnt_i = CW'(cv);
                            #1;
                            e = sl[0] & ex[0] & ((t == 0) || (cv == nbytes(s)));
                            chk((t == 0) ? "R11" : "R12", {31'd0, ack_o}, {31'd0, e});
                        end
        sel_i = 0; ext_req_i = 0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule